// File: doc/BRIEF.md
# Segmented Current-Steering Switch Decoder

This block turns a 14-bit unsigned sample word into the switch controls of a segmented current-steering converter array. The word is captured on the rising clock edge. The five most significant bits select how many of 31 equal coarse cells conduct to output A. The next four bits select how many of 15 equal fine cells conduct. Each fine cell carries one sixteenth of a coarse cell. The five least significant bits drive binary-weighted tail cells directly.

Every cell has a complementary pair of drive lines, one steering its current to output A and the other to output B. The decoded pairs pass through a second register bank, so every switch in the array changes on the same edge.

A sleep input parks the whole array in the idle state, which is the code-0 state with every cell steered to B. While sleep is high, incoming words are discarded. Downstream, the drive lines feed the analog switch matrix directly.

Top module: `seg_switch_decoder`

## Requirements
- R1: A word present on `din` at a rising edge where `rst` and `sleep` are both low appears on the drive outputs after exactly two rising edges, and not earlier.
- R2: The count of set bits in `top_a` equals `din[13:9]`. The set bits are the lowest-indexed ones: bit i is 1 exactly when i is less than that value.
- R3: The count of set bits in `mid_a` equals `din[8:5]`, filled from bit 0 upward in the same thermometer order.
- R4: `low_a[i]` equals `din[i]` for i from 0 to 4.
- R5: For every cell, the B line is always the inverse of the A line (`top_b == ~top_a`, `mid_b == ~mid_a`, `low_b == ~low_a`). Both lines of a pair are never high together.
- R6: With weights 512 per top cell, 32 per middle cell and 16/8/4/2/1 for `low_a[4:0]`, the A-side weighted total equals the code. The B-side weighted total equals 16383 minus the code. At code 16383 all A lines are 1 and all B lines are 0.
- R7: While `sleep` is high, the outputs go to the idle state (all A lines 0, all B lines 1) one edge after sleep is first seen, and words on `din` are ignored. After release, the first word captured with sleep low reaches the outputs two edges later.
- R8: A synchronous active-high `rst` clears both register stages, so the outputs show the idle state of R7 one edge after reset is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| sleep | input | 1 | Park array in idle state, discard input |
| din | input | 14 | Unsigned sample code |
| top_a | output | 31 | Coarse cells steered to A |
| top_b | output | 31 | Coarse cells steered to B |
| mid_a | output | 15 | Fine cells steered to A |
| mid_b | output | 15 | Fine cells steered to B |
| low_a | output | 5 | Binary tail cells steered to A |
| low_b | output | 5 | Binary tail cells steered to B |

## Verification
All decoded results are due two rising edges after the word is driven. The idle state forced by sleep or reset is due one edge after the control is sampled.

The bench drives inputs on the falling edge. At every rising edge it advances a two-deep reference pipeline built from these timing rules. At the following falling edge it compares every output field against that pipeline's last stage. A result that arrives a cycle early or late therefore mismatches.

// File: rtl/segdac_pkg.sv
package segdac_pkg;
  localparam int unsigned DEF_TOP_BITS = 5;
  localparam int unsigned DEF_MID_BITS = 4;
  localparam int unsigned DEF_LOW_BITS = 5;

  // Number of unary cells needed for a field of the given width
  function automatic int unsigned unary_cells(input int unsigned bits);
    return (1 << bits) - 1;
  endfunction
endpackage

// File: rtl/seg_capture.sv
module seg_capture #(
  parameter int unsigned CODE_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep,
  input  logic [CODE_W-1:0] din,
  output logic [CODE_W-1:0] cap
);
  always_ff @(posedge clk) begin
    if (rst || sleep) cap <= '0;
    else              cap <= din;
  end

  // R7: a sampled sleep discards the incoming word
  a_r7_sleep_drops_word: assert property (@(posedge clk) disable iff (rst)
    sleep |=> (cap == '0));
endmodule

// File: rtl/seg_thermo.sv
module seg_thermo #(
  parameter int unsigned IN_W = 5,
  localparam int unsigned OUT_N = (1 << IN_W) - 1
) (
  input  logic [IN_W-1:0]  val,
  output logic [OUT_N-1:0] therm
);
  for (genvar g = 0; g < OUT_N; g++) begin : g_cell
    assign therm[g] = (32'(val) > g);
  end
endmodule

// File: rtl/seg_drive_reg.sv
module seg_drive_reg #(
  parameter int unsigned W = 31
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold,
  input  logic [W-1:0] d,
  output logic [W-1:0] q_a,
  output logic [W-1:0] q_b
);
  // Separate A and B banks so each switch side has its own matched flop
  always_ff @(posedge clk) begin
    if (rst || hold) q_a <= '0;
    else             q_a <= d;
  end

  always_ff @(posedge clk) begin
    if (rst || hold) q_b <= '1;
    else             q_b <= ~d;
  end

  // R5: pair lines stay complementary
  a_r5_pair_complement: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((q_a ^ q_b) == '1));

  // R7: hold forces idle state on the next edge
  a_r7_hold_idle: assert property (@(posedge clk) disable iff (rst)
    hold |=> (q_a == '0 && q_b == '1));

  // R8: reset leaves the idle state behind it
  a_r8_reset_idle: assert property (@(posedge clk)
    rst |=> (q_a == '0 && q_b == '1));
endmodule

// File: rtl/seg_switch_decoder.sv
module seg_switch_decoder
  import segdac_pkg::*;
#(
  parameter int unsigned TOP_BITS = DEF_TOP_BITS,
  parameter int unsigned MID_BITS = DEF_MID_BITS,
  parameter int unsigned LOW_BITS = DEF_LOW_BITS,
  localparam int unsigned CODE_W = TOP_BITS + MID_BITS + LOW_BITS,
  localparam int unsigned TOP_N  = (1 << TOP_BITS) - 1,
  localparam int unsigned MID_N  = (1 << MID_BITS) - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep,
  input  logic [CODE_W-1:0] din,
  output logic [TOP_N-1:0]  top_a,
  output logic [TOP_N-1:0]  top_b,
  output logic [MID_N-1:0]  mid_a,
  output logic [MID_N-1:0]  mid_b,
  output logic [LOW_BITS-1:0] low_a,
  output logic [LOW_BITS-1:0] low_b
);
  localparam int unsigned MID_LSB = LOW_BITS;
  localparam int unsigned TOP_LSB = LOW_BITS + MID_BITS;
  localparam int unsigned TOP_WT  = 1 << TOP_LSB;
  localparam int unsigned MID_WT  = 1 << MID_LSB;
  localparam int unsigned FULL    = (1 << CODE_W) - 1;

  logic [CODE_W-1:0] cap;
  logic [TOP_N-1:0]  top_dec;
  logic [MID_N-1:0]  mid_dec;

  // Stage 1: input capture
  seg_capture #(.CODE_W(CODE_W)) u_cap (
    .clk(clk), .rst(rst), .sleep(sleep), .din(din), .cap(cap)
  );

  // Segment decoders
  seg_thermo #(.IN_W(TOP_BITS)) u_top_dec (
    .val(cap[CODE_W-1:TOP_LSB]), .therm(top_dec)
  );
  seg_thermo #(.IN_W(MID_BITS)) u_mid_dec (
    .val(cap[TOP_LSB-1:MID_LSB]), .therm(mid_dec)
  );

  // Stage 2: aligned drive banks
  seg_drive_reg #(.W(TOP_N)) u_top_drv (
    .clk(clk), .rst(rst), .hold(sleep), .d(top_dec), .q_a(top_a), .q_b(top_b)
  );
  seg_drive_reg #(.W(MID_N)) u_mid_drv (
    .clk(clk), .rst(rst), .hold(sleep), .d(mid_dec), .q_a(mid_a), .q_b(mid_b)
  );
  seg_drive_reg #(.W(LOW_BITS)) u_low_drv (
    .clk(clk), .rst(rst), .hold(sleep), .d(cap[LOW_BITS-1:0]),
    .q_a(low_a), .q_b(low_b)
  );

  // ---- checks ----
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst)           age <= '0;
    else if (age != 2) age <= age + 2'd1;
  end

  int unsigned wsum_a, wsum_b;
  always_comb begin
    wsum_a = $countones(top_a) * TOP_WT + $countones(mid_a) * MID_WT + 32'(low_a);
    wsum_b = $countones(top_b) * TOP_WT + $countones(mid_b) * MID_WT + 32'(low_b);
  end

  // R2: coarse group is a thermometer
  a_r2_top_thermo: assert property (@(posedge clk) disable iff (rst)
    ((top_a & (top_a + 1'b1)) == '0));

  // R3: fine group is a thermometer
  a_r3_mid_thermo: assert property (@(posedge clk) disable iff (rst)
    ((mid_a & (mid_a + 1'b1)) == '0));

  // R1, R6: weighted totals track the word two edges back
  a_r6_sum_matches_code: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2 && !$past(sleep) && !$past(sleep, 2)) |->
      (wsum_a == 32'($past(din, 2)) && wsum_b == FULL - 32'($past(din, 2))));
endmodule

// File: tb/seg_switch_decoder_bench.sv
module seg_switch_decoder_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sleep = 1'b0;
  logic [13:0] din = '0;
  logic [30:0] top_a, top_b;
  logic [14:0] mid_a, mid_b;
  logic [4:0]  low_a, low_b;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #10 clk = ~clk;  // 50 MHz

  seg_switch_decoder u_seg_switch_decoder (
    .clk(clk), .rst(rst), .sleep(sleep), .din(din),
    .top_a(top_a), .top_b(top_b), .mid_a(mid_a), .mid_b(mid_b),
    .low_a(low_a), .low_b(low_b)
  );

  // Reference pipeline from R1/R7/R8 timing rules
  int st1 = 0;
  int st2 = 0;
  always @(posedge clk) begin
    cycles++;
    if (rst || sleep) begin st2 = 0; st1 = 0; end
    else begin st2 = st1; st1 = int'(din); end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic check_all(input string tag);
    int e = st2;
    int nt = e >> 9;
    int nm = (e >> 5) & 15;
    chk({"R2 top count ", tag}, $countones(top_a), nt);
    chk({"R2 top order ", tag}, int'(top_a), (1 << nt) - 1);
    chk({"R3 mid order ", tag}, int'(mid_a), (1 << nm) - 1);
    chk({"R4 low bits ", tag}, int'(low_a), e & 31);
    chk({"R5 complement ", tag},
        int'(((top_a ^ top_b) == '1) && ((mid_a ^ mid_b) == '1) && ((low_a ^ low_b) == '1)), 1);
    chk({"R6 sum A ", tag},
        $countones(top_a) * 512 + $countones(mid_a) * 32 + int'(low_a), e);
    chk({"R6 sum B ", tag},
        $countones(top_b) * 512 + $countones(mid_b) * 32 + int'(low_b), 16383 - e);
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic apply(input int code, input string tag);
    din = 14'(code);
    step(tag);
  endtask

  initial begin
    // R8: reset state
    @(negedge clk);
    step("R8 reset");
    step("R8 reset");
    chk("R8 idle A lines", int'(top_a != 0 || mid_a != 0 || low_a != 0), 0);
    rst = 1'b0;

    // R1: latency, one edge later old value still present
    din = 14'd16383;
    @(posedge clk); @(negedge clk);
    chk("R1 not early", $countones(top_a), 0);
    check_all("R1 first edge");
    step("R1 second edge");
    chk("R6 full scale all A", int'(top_a == '1 && mid_a == '1 && low_a == '1), 1);

    apply(0, "R6 zero");
    apply(1, "R4 one");
    apply(511, "R3 511");
    apply(512, "R2 512");
    apply(8192, "R2 mid");
    apply(16383, "R6 full");
    apply(16383, "R6 full");
    for (int i = 0; i < 200; i++) apply(int'($urandom_range(0, 16383)), "R1 random");

    // R7: sleep with changing inputs
    sleep = 1'b1;
    for (int i = 0; i < 6; i++) apply(16383 - i * 77, "R7 sleeping");
    chk("R7 idle during sleep", int'(top_b == '1 && mid_b == '1 && low_b == '1), 1);
    sleep = 1'b0;
    apply(12345, "R7 release");
    chk("R7 first after release not early", int'(low_a), 0);
    apply(777, "R7 resume");
    chk("R7 resume value", $countones(top_a) * 512 + $countones(mid_a) * 32 + int'(low_a), 12345);
    apply(777, "R7 resume");

    // R8: reset mid-run
    apply(9000, "R8 pre");
    rst = 1'b1;
    apply(4000, "R8 midrun");
    chk("R8 midrun idle", int'(top_a == 0 && mid_a == 0 && low_a == 0), 1);
    rst = 1'b0;
    for (int i = 0; i < 50; i++) apply(int'($urandom_range(0, 16383)), "R2 random");
    apply(0, "R6 zero end");
    apply(0, "R6 zero end");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cycles > 5000);
    failures++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 5000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule